// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock for an I2C controller. Every SCL period is built from ten equal units: six during which the block pulls SCL low, and four during which it lets SCL go high. One unit lasts (1 + TPR) functional clocks. TPR is a 7-bit period value. The functional clock arrives as a one-cycle enable pulse on the system clock, and all period counting advances only on enabled cycles.

The sampled SCL and SDA lines each pass through a two-flop synchronizer and a selectable glitch filter. The filtered levels are available as status outputs. When the high phase is gated, either by multi-controller mode or by the clock-stretch enable, the high-phase count is held until the filtered SCL level is actually high. This lets another controller or a stretching target lengthen the high phase. Two single-cycle strobes mark the middle of the low phase, where data may change, and the middle of the high phase, where data is sampled. A surrounding controller uses these strobes to drive and capture SDA.

Top module: `scl_period_gen`

## Requirements
- R1: With functional-clock enable held high, the SCL low phase (drive request asserted) lasts 6 × (1 + TPR) clock cycles.
- R2: With the high phase ungated, the SCL high phase (drive request released) lasts 4 × (1 + TPR) clock cycles.
- R3: A TPR value of 0 is treated as 1.
- R4: Unit counting advances only on cycles where the functional-clock enable is high. With the enable high on every other cycle, each phase takes twice as many clock cycles.
- R5: In multi-controller mode, high-phase counting starts only once the filtered SCL level is high. The filtered level lags the pin by two synchronizer cycles plus the filter delay.
- R6: With clock-stretch enabled, an external device holding SCL low after release lengthens the high phase by the hold time. With neither gating mode enabled, such a hold has no effect on the high-phase length.
- R7: Glitch select 0 passes the synchronized level straight through. A value N ≥ 1 changes the filtered level only after N consecutive enabled samples of the new level, so shorter pulses are suppressed.
- R8: The SCL and SDA status outputs carry the filtered line levels and read 1 out of reset.
- R9: The data-change strobe pulses for one cycle at the end of the third low unit, that is, 3 × (1 + TPR) cycles into the low phase.
- R10: The data-sample strobe pulses for one cycle at the end of the second counted high unit.
- R11: While the run input is low, SCL is released and the counters reset. After run rises, the first low phase has the full length.
- R12: In reset, the drive request and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fclk_en_i | input | 1 | Functional-clock enable pulse |
| run_i | input | 1 | Generator enable |
| tpr_i | input | 7 | Timer period value |
| gsel_i | input | 4 | Glitch filter select |
| multi_ctrl_i | input | 1 | Gate high-phase count on observed SCL high |
| stretch_en_i | input | 1 | Honour target clock stretching |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_drive_low_o | output | 1 | Open-drain request to pull SCL low |
| data_change_o | output | 1 | Mid-low strobe |
| data_sample_o | output | 1 | Mid-high strobe |
| scl_status_o | output | 1 | Filtered SCL level |
| sda_status_o | output | 1 | Filtered SDA level |

## Verification
The bench builds the block with its default widths: a 7-bit period and a 4-bit glitch select. This brings the largest period (TPR 127, 1280 cycles per SCL period) and the illegal value 0 into reach within one run. The bench loops SCL back from the drive request, so gated high phases show the real synchronizer and filter delay. An injected external hold demonstrates stretching. A half-rate enable pattern and filter selects of 0, 3 and 7 cover the enable and filter paths.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int unsigned LOW_UNITS  = 6;
  localparam int unsigned HIGH_UNITS = 4;
  localparam int unsigned UNIT_W     = $clog2(LOW_UNITS);
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
  parameter int unsigned GSEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [GSEL_W-1:0] gsel_i,
  input  logic              line_i,
  output logic              level_o
);
  logic [1:0]        sync_q;
  logic              lvl_q;
  logic [GSEL_W-1:0] cnt_q;
  logic              smp;

  assign smp = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (en_i) begin
      if (gsel_i == '0) begin
        lvl_q <= smp;
        cnt_q <= '0;
      end else if (smp == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == gsel_i - 1'b1) begin
        lvl_q <= smp;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // select 0: bypass, synchronized level passes straight through
  assign level_o = (gsel_i == '0) ? smp : lvl_q;
endmodule

// File: rtl/scl_unit_timer.sv
module scl_unit_timer #(
  parameter int unsigned TPR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic [TPR_W-1:0] tpr_i,
  output logic             tick_o
);
  logic [TPR_W-1:0] presc_q;
  logic [TPR_W-1:0] tpr_eff;

  assign tpr_eff = (tpr_i == '0) ? TPR_W'(1) : tpr_i;
  assign tick_o  = en_i & ~hold_i & ~clear_i & (presc_q >= tpr_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                presc_q <= '0;
    else if (clear_i)           presc_q <= '0;
    else if (en_i && !hold_i)   presc_q <= tick_o ? '0 : presc_q + 1'b1;
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   clear_i,
  output phase_e phase_o,
  output logic   mid_low_o,
  output logic   mid_high_o
);
  phase_e            phase_q;
  logic [UNIT_W-1:0] unit_q;
  logic              last_unit;

  always_comb begin
    if (phase_q == PH_LOW) last_unit = (unit_q == UNIT_W'(LOW_UNITS - 1));
    else                   last_unit = (unit_q == UNIT_W'(HIGH_UNITS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      unit_q  <= '0;
    end else if (clear_i) begin
      phase_q <= PH_LOW;
      unit_q  <= '0;
    end else if (tick_i) begin
      if (last_unit) begin
        phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        unit_q  <= '0;
      end else begin
        unit_q  <= unit_q + 1'b1;
      end
    end
  end

  assign phase_o    = phase_q;
  assign mid_low_o  = tick_i & (phase_q == PH_LOW)  & (unit_q == UNIT_W'(LOW_UNITS / 2 - 1));
  assign mid_high_o = tick_i & (phase_q == PH_HIGH) & (unit_q == UNIT_W'(HIGH_UNITS / 2 - 1));
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned TPR_W  = 7,
  parameter int unsigned GSEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fclk_en_i,
  input  logic              run_i,
  input  logic [TPR_W-1:0]  tpr_i,
  input  logic [GSEL_W-1:0] gsel_i,
  input  logic              multi_ctrl_i,
  input  logic              stretch_en_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low_o,
  output logic              data_change_o,
  output logic              data_sample_o,
  output logic              scl_status_o,
  output logic              sda_status_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_lvl;
  phase_e            phase;
  logic              tick;
  logic              hold;
  logic              clear;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    scl_line_filter #(.GSEL_W(GSEL_W)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (fclk_en_i),
      .gsel_i (gsel_i),
      .line_i (line_in[g]),
      .level_o(line_lvl[g])
    );
  end

  assign clear = ~run_i;
  // high phase waits for the line to be seen high when gated
  assign hold  = (phase == PH_HIGH) & (multi_ctrl_i | stretch_en_i) & ~line_lvl[0];

  scl_unit_timer #(.TPR_W(TPR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fclk_en_i),
    .hold_i (hold),
    .clear_i(clear),
    .tpr_i  (tpr_i),
    .tick_o (tick)
  );

  scl_phase_ctrl u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .clear_i   (clear),
    .phase_o   (phase),
    .mid_low_o (data_change_o),
    .mid_high_o(data_sample_o)
  );

  assign scl_drive_low_o = run_i & (phase == PH_LOW);
  assign scl_status_o    = line_lvl[0];
  assign sda_status_o    = line_lvl[1];
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int unsigned GSEL_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fclk_en_i,
  input logic              run_i,
  input logic [GSEL_W-1:0] gsel_i,
  input logic              scl_drive_low_o,
  input logic              data_change_o,
  input logic              data_sample_o,
  input logic              scl_status_o
);
  p_idle_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!scl_drive_low_o && !data_change_o && !data_sample_o));

  p_change_in_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_change_o |-> scl_drive_low_o);

  p_change_not_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_change_o && run_i) |=> (scl_drive_low_o || !run_i));

  p_sample_in_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_sample_o |-> !scl_drive_low_o);

  p_strobes_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_change_o && data_sample_o));

  p_filter_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gsel_i != '0 && !fclk_en_i) |=> (gsel_i == '0 || $stable(scl_status_o)));
endmodule

bind scl_period_gen scl_period_gen_chk #(.GSEL_W(GSEL_W)) u_chk (.*);

// File: tb/tb_scl_period_gen.sv
module tb_scl_period_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fclk_en_i = 1'b1;
  logic       run_i = 1'b0;
  logic [6:0] tpr_i = 7'd1;
  logic [3:0] gsel_i = 4'd0;
  logic       multi_ctrl_i = 1'b0;
  logic       stretch_en_i = 1'b0;
  logic       sda_i = 1'b1;
  logic       ext_sel = 1'b0;
  logic       ext_val = 1'b1;
  logic       hold_low = 1'b0;
  logic       half_rate = 1'b0;
  logic       scl_i;
  logic       scl_drive_low_o, data_change_o, data_sample_o, scl_status_o, sda_status_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_len = 0, low_len = 0, high_len = 0, chg_pos = 0, smp_pos = 0;
  logic prev_drv = 1'b0;

  always #10 clk_i = ~clk_i;

  assign scl_i = ext_sel ? ext_val : (!scl_drive_low_o && !hold_low);

  scl_period_gen dut (.*);

  always @(posedge clk_i) begin
    #1;
    if (half_rate) fclk_en_i = ~fclk_en_i;
    else           fclk_en_i = 1'b1;
  end

  always @(negedge clk_i) begin
    if (scl_drive_low_o == prev_drv) cur_len++;
    else begin
      if (prev_drv) low_len = cur_len;
      else          high_len = cur_len;
      cur_len  = 1;
      prev_drv = scl_drive_low_o;
    end
    if (data_change_o) chg_pos = cur_len;
    if (data_sample_o) smp_pos = cur_len;
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_drive(input logic v);
    do @(posedge clk_i) #1; while (scl_drive_low_o !== v);
  endtask

  task automatic finish_tb;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // tpr, multi, gsel, low, high, change pos, sample pos
  typedef struct packed {
    logic [6:0]  tpr;
    logic        multi;
    logic [3:0]  gsel;
    logic [15:0] low;
    logic [15:0] high;
    logic [15:0] chg;
    logic [15:0] smp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{7'd1,   1'b0, 4'd0, 16'd12,  16'd8,   16'd6,   16'd4},
    '{7'd4,   1'b0, 4'd0, 16'd30,  16'd20,  16'd15,  16'd10},
    '{7'd0,   1'b0, 4'd0, 16'd12,  16'd8,   16'd6,   16'd4},
    '{7'd127, 1'b0, 4'd0, 16'd768, 16'd512, 16'd384, 16'd256},
    '{7'd2,   1'b1, 4'd0, 16'd18,  16'd14,  16'd9,   16'd8},
    '{7'd2,   1'b1, 4'd3, 16'd18,  16'd17,  16'd9,   16'd11},
    '{7'd5,   1'b0, 4'd7, 16'd36,  16'd24,  16'd18,  16'd12}
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    // R12 / R8 reset state
    repeat (2) @(negedge clk_i);
    chk(scl_drive_low_o, 0, "R12 drive in reset");
    chk(data_change_o | data_sample_o, 0, "R12 strobes in reset");
    chk(scl_status_o, 1, "R8 scl status reset");
    chk(sda_status_o, 1, "R8 sda status reset");
    @(posedge clk_i) #1 rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk_i) #1;
      run_i = 0; tpr_i = VECS[i].tpr; multi_ctrl_i = VECS[i].multi; gsel_i = VECS[i].gsel;
      repeat (3) @(posedge clk_i);
      #1 run_i = 1;
      wait_drive(0); wait_drive(1); wait_drive(0);
      @(negedge clk_i) #1;
      chk(low_len, int'(VECS[i].low), $sformatf("R1/R3 low len vec%0d", i));
      chk(chg_pos, int'(VECS[i].chg), $sformatf("R9 change pos vec%0d", i));
      wait_drive(1);
      @(negedge clk_i) #1;
      chk(high_len, int'(VECS[i].high), $sformatf("R2/R5 high len vec%0d", i));
      chk(smp_pos, int'(VECS[i].smp), $sformatf("R10 sample pos vec%0d", i));
    end

    // R6 stretch: hold SCL low 5 cycles after release
    @(posedge clk_i) #1;
    run_i = 0; tpr_i = 7'd1; multi_ctrl_i = 0; stretch_en_i = 1; gsel_i = 0;
    repeat (3) @(posedge clk_i);
    #1 run_i = 1;
    wait_drive(0);
    hold_low = 1;
    repeat (5) @(posedge clk_i);
    #1 hold_low = 0;
    wait_drive(1);
    @(negedge clk_i) #1;
    chk(high_len, 15, "R6 stretched high");

    // R6 no gating: hold ignored
    @(posedge clk_i) #1 stretch_en_i = 0;
    wait_drive(0);
    hold_low = 1;
    repeat (5) @(posedge clk_i);
    #1 hold_low = 0;
    wait_drive(1);
    @(negedge clk_i) #1;
    chk(high_len, 8, "R6 ungated hold ignored");

    // R11 restart mid low phase
    wait_drive(1);
    repeat (4) @(posedge clk_i);
    #1 run_i = 0;
    @(negedge clk_i) #1;
    chk(scl_drive_low_o, 0, "R11 released when idle");
    repeat (3) @(posedge clk_i);
    #1 run_i = 1;
    wait_drive(0);
    @(negedge clk_i) #1;
    chk(low_len, 12, "R11 full first low");

    // R4 half-rate enable
    @(posedge clk_i) #1 half_rate = 1;
    wait_drive(1); wait_drive(0);
    @(negedge clk_i) #1;
    chk(low_len, 24, "R4 half-rate low");
    wait_drive(1);
    @(negedge clk_i) #1;
    chk(high_len, 16, "R4 half-rate high");
    @(posedge clk_i) #1 half_rate = 0; run_i = 0;

    // R7 glitch filter, select 3
    repeat (2) @(posedge clk_i);
    #1 ext_sel = 1; gsel_i = 4'd3; ext_val = 0;
    repeat (2) @(posedge clk_i);
    #1 ext_val = 1;
    repeat (6) @(negedge clk_i);
    chk(scl_status_o, 1, "R7 short pulse suppressed");
    @(posedge clk_i) #1 ext_val = 0;
    repeat (3) @(posedge clk_i);
    #1 ext_val = 1;
    repeat (4) @(negedge clk_i);
    chk(scl_status_o, 0, "R7 long pulse passed");
    repeat (8) @(negedge clk_i);
    chk(scl_status_o, 1, "R7 level restored");

    // R7 bypass: one-cycle pulse visible
    @(posedge clk_i) #1 gsel_i = 0; ext_val = 0;
    @(posedge clk_i) #1 ext_val = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(scl_status_o, 0, "R7 bypass pulse");

    // R8 SDA follows line
    @(posedge clk_i) #1 sda_i = 0;
    repeat (3) @(negedge clk_i);
    chk(sda_status_o, 0, "R8 sda status low");
    @(posedge clk_i) #1 sda_i = 1;
    repeat (3) @(negedge clk_i);
    chk(sda_status_o, 1, "R8 sda status high");

    finish_tb();
  end
endmodule